// File: doc/BRIEF.md
# Multi-Source Reset Sequencer with Status

This block is the reset controller of a small microcontroller. It takes five reset causes and turns each into a reset sequence: a power-on pulse, a watchdog overflow, a low-voltage comparator flag, an illegal-opcode strobe (including a STOP instruction while stopping is disabled), and an opcode fetch from an unmapped address. It drives an open-drain external reset pin, holds the CPU in internal reset, and gates the internal clocks while the oscillator settles. All timing counts cycles of the fast (4x) clock that clocks the block.

Each cause runs its own sequence. A power-on gates the clocks for a stabilization delay and then keeps the pin low for a short tail. A low-voltage condition holds everything while the flag stays high, then runs the stabilization delay. The internal faults only pull the pin low for the tail while the clocks keep running. An eight-bit status register records the causes. It can be read on the bus but not written. A write of any value to the watchdog control address produces a clear strobe for the external watchdog counter.

Top module: `rstseq_top`

## Requirements
- R1: After the block's reset or a `por_i` pulse, `clk_en_o` is low for exactly STAB_CYC cycles. `rst_pin_drv_o` (1 = pin pulled low) stays high for those cycles plus TAIL_CYC further cycles.
- R2: A power-on sets the status register to exactly 8'h80 (POR in bit 7) and clears every other cause bit, even when another source fires in the same cycle.
- R3: `wdt_ovf_i` drives the pin for TAIL_CYC cycles with `clk_en_o` held high, and sets status bit 5.
- R4: `illop_i`, or `stop_i` while `stop_en_i` is 0, drives the pin for TAIL_CYC cycles and sets status bit 4. `stop_i` while `stop_en_i` is 1 causes no reset.
- R5: `unmapped_i` with `fetch_i` high drives the pin for TAIL_CYC cycles and sets status bit 3. `unmapped_i` with `fetch_i` low causes no reset.
- R6: While `lvd_i` is high, the pin is driven and the clocks are gated. After it falls, both continue for STAB_CYC more cycles with no tail. Status bit 1 is set.
- R7: A source other than power-on sets only its own status bit and keeps the bits already recorded.
- R8: `int_rst_o` is high while the pin is driven and falls one clock edge after the pin is released.
- R9: A new source during stabilization restarts the delay count from zero. When the restart interrupts a power-on sequence, the tail still follows.
- R10: `stat_rdata_o` shows the status when `bus_rd_i` is high and `bus_addr_i` equals STAT_ADDR, and is 0 otherwise. A bus write to STAT_ADDR leaves the status unchanged.
- R11: `wdt_clr_o` is high in the same cycle as a bus write to WDT_ADDR, and low for writes to any other address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast (4x) clock |
| rst_ni | input | 1 | Asynchronous active-low reset, acts as power-on |
| por_i | input | 1 | Power-on reset pulse |
| lvd_i | input | 1 | Low-voltage comparator flag (level) |
| wdt_ovf_i | input | 1 | Watchdog overflow strobe |
| illop_i | input | 1 | Decoded illegal opcode strobe |
| stop_i | input | 1 | STOP instruction executed strobe |
| stop_en_i | input | 1 | Stop-enable configuration bit |
| unmapped_i | input | 1 | Access to an unmapped address |
| fetch_i | input | 1 | Qualifies the access as an opcode fetch |
| bus_addr_i | input | AW | Bus address |
| bus_rd_i | input | 1 | Bus read strobe |
| bus_wr_i | input | 1 | Bus write strobe |
| stat_rdata_o | output | 8 | Status read data |
| wdt_clr_o | output | 1 | Watchdog counter clear strobe |
| rst_pin_drv_o | output | 1 | Pull the open-drain reset pin low |
| int_rst_o | output | 1 | Internal CPU reset |
| clk_en_o | output | 1 | Internal clock enable |

## Verification
Two functions can land in the same cycle: the status update and the sequence restart. The bench fires a power-on pulse and a watchdog overflow on the same edge. It then expects a status of 8'h80 and a full power-on sequence, so the power-on clearing has to win over the overflow setting its bit. It also fires a watchdog overflow ten cycles into a power-on stabilization. It then expects a fresh full-length delay followed by the power-on tail, which shows the restart kept the tail request.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;

  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_HOLD = 2'd1,
    ST_STAB = 2'd2,
    ST_TAIL = 2'd3
  } seq_state_e;

  typedef struct packed {
    logic por;
    logic cop;
    logic ilop;
    logic ilad;
    logic lvd;
  } src_evt_t;

  localparam int unsigned BIT_POR  = 7;
  localparam int unsigned BIT_COP  = 5;
  localparam int unsigned BIT_ILOP = 4;
  localparam int unsigned BIT_ILAD = 3;
  localparam int unsigned BIT_LVI  = 1;

endpackage

// File: rtl/rstseq_src.sv
module rstseq_src
  import rstseq_pkg::*;
(
  input  logic     por_i,
  input  logic     lvd_i,
  input  logic     wdt_ovf_i,
  input  logic     illop_i,
  input  logic     stop_i,
  input  logic     stop_en_i,
  input  logic     unmapped_i,
  input  logic     fetch_i,
  output src_evt_t evt_o,
  output logic     int_evt_o
);

  always_comb begin
    evt_o.por  = por_i;
    evt_o.lvd  = lvd_i;
    evt_o.cop  = wdt_ovf_i;
    evt_o.ilop = illop_i | (stop_i & ~stop_en_i);
    evt_o.ilad = unmapped_i & fetch_i;
    int_evt_o  = evt_o.cop | evt_o.ilop | evt_o.ilad;
  end

endmodule

// File: rtl/rstseq_fsm.sv
module rstseq_fsm
  import rstseq_pkg::*;
#(
  parameter int unsigned STAB_CYC = 4096,
  parameter int unsigned TAIL_CYC = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic por_evt_i,
  input  logic lvd_i,
  input  logic int_evt_i,
  output logic pin_drv_o,
  output logic int_rst_o,
  output logic clk_en_o
);

  localparam int unsigned MAXC = (STAB_CYC > TAIL_CYC) ? STAB_CYC : TAIL_CYC;
  localparam int unsigned CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] STAB_LAST = CW'(STAB_CYC - 1);
  localparam logic [CW-1:0] TAIL_LAST = CW'(TAIL_CYC - 1);

  seq_state_e      state_q, state_d;
  logic [CW-1:0]   cnt_q, cnt_d;
  logic            tail_q, tail_d;
  logic            irst_q;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    tail_d  = tail_q;
    if (lvd_i) begin
      state_d = ST_HOLD;
      cnt_d   = '0;
      tail_d  = 1'b0;
    end else if (por_evt_i) begin
      state_d = ST_STAB;
      cnt_d   = '0;
      tail_d  = 1'b1;
    end else begin
      unique case (state_q)
        ST_RUN: begin
          if (int_evt_i) begin
            state_d = ST_TAIL;
            cnt_d   = '0;
          end
        end
        ST_HOLD: begin
          state_d = ST_STAB;
          cnt_d   = '0;
        end
        ST_STAB: begin
          if (int_evt_i) begin
            cnt_d = '0;
          end else if (cnt_q == STAB_LAST) begin
            state_d = tail_q ? ST_TAIL : ST_RUN;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        ST_TAIL: begin
          if (int_evt_i) begin
            cnt_d = '0;
          end else if (cnt_q == TAIL_LAST) begin
            state_d = ST_RUN;
            cnt_d   = '0;
            tail_d  = 1'b0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        default: state_d = ST_RUN;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_STAB;
      cnt_q   <= '0;
      tail_q  <= 1'b1;
      irst_q  <= 1'b1;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      tail_q  <= tail_d;
      irst_q  <= pin_drv_o;
    end
  end

  assign pin_drv_o = (state_q != ST_RUN);
  assign clk_en_o  = (state_q == ST_RUN) || (state_q == ST_TAIL);
  assign int_rst_o = irst_q;

endmodule

// File: rtl/rstseq_status.sv
module rstseq_status
  import rstseq_pkg::*;
#(
  parameter int unsigned AW        = 16,
  parameter logic [AW-1:0] STAT_ADDR = 16'hFE01,
  parameter logic [AW-1:0] WDT_ADDR  = 16'hFFFF
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  src_evt_t      evt_i,
  input  logic [AW-1:0] bus_addr_i,
  input  logic          bus_rd_i,
  input  logic          bus_wr_i,
  output logic [7:0]    stat_o,
  output logic [7:0]    rdata_o,
  output logic          wdt_clr_o
);

  logic [7:0] stat_q, stat_d;

  always_comb begin
    stat_d = stat_q;
    if (evt_i.por) begin
      stat_d = 8'h00;
      stat_d[BIT_POR] = 1'b1;
    end else begin
      if (evt_i.cop)  stat_d[BIT_COP]  = 1'b1;
      if (evt_i.ilop) stat_d[BIT_ILOP] = 1'b1;
      if (evt_i.ilad) stat_d[BIT_ILAD] = 1'b1;
      if (evt_i.lvd)  stat_d[BIT_LVI]  = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= 8'(1 << BIT_POR);
    end else begin
      stat_q <= stat_d;
    end
  end

  assign stat_o    = stat_q;
  assign rdata_o   = (bus_rd_i && (bus_addr_i == STAT_ADDR)) ? stat_q : 8'h00;
  assign wdt_clr_o = bus_wr_i && (bus_addr_i == WDT_ADDR);

endmodule

// File: rtl/rstseq_top.sv
module rstseq_top
  import rstseq_pkg::*;
#(
  parameter int unsigned   STAB_CYC  = 4096,
  parameter int unsigned   TAIL_CYC  = 32,
  parameter int unsigned   AW        = 16,
  parameter logic [AW-1:0] STAT_ADDR = 16'hFE01,
  parameter logic [AW-1:0] WDT_ADDR  = 16'hFFFF
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          por_i,
  input  logic          lvd_i,
  input  logic          wdt_ovf_i,
  input  logic          illop_i,
  input  logic          stop_i,
  input  logic          stop_en_i,
  input  logic          unmapped_i,
  input  logic          fetch_i,
  input  logic [AW-1:0] bus_addr_i,
  input  logic          bus_rd_i,
  input  logic          bus_wr_i,
  output logic [7:0]    stat_rdata_o,
  output logic          wdt_clr_o,
  output logic          rst_pin_drv_o,
  output logic          int_rst_o,
  output logic          clk_en_o
);

  src_evt_t   evt;
  logic       int_evt;
  logic       any_evt;
  logic [7:0] stat_q;

  rstseq_src u_src (
    .por_i      (por_i),
    .lvd_i      (lvd_i),
    .wdt_ovf_i  (wdt_ovf_i),
    .illop_i    (illop_i),
    .stop_i     (stop_i),
    .stop_en_i  (stop_en_i),
    .unmapped_i (unmapped_i),
    .fetch_i    (fetch_i),
    .evt_o      (evt),
    .int_evt_o  (int_evt)
  );

  rstseq_fsm #(
    .STAB_CYC (STAB_CYC),
    .TAIL_CYC (TAIL_CYC)
  ) u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .por_evt_i (evt.por),
    .lvd_i     (evt.lvd),
    .int_evt_i (int_evt),
    .pin_drv_o (rst_pin_drv_o),
    .int_rst_o (int_rst_o),
    .clk_en_o  (clk_en_o)
  );

  rstseq_status #(
    .AW        (AW),
    .STAT_ADDR (STAT_ADDR),
    .WDT_ADDR  (WDT_ADDR)
  ) u_stat (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .evt_i      (evt),
    .bus_addr_i (bus_addr_i),
    .bus_rd_i   (bus_rd_i),
    .bus_wr_i   (bus_wr_i),
    .stat_o     (stat_q),
    .rdata_o    (stat_rdata_o),
    .wdt_clr_o  (wdt_clr_o)
  );

  assign any_evt = evt.por | evt.lvd | int_evt;

endmodule

// File: rtl/rstseq_chk.sv
module rstseq_chk #(
  parameter int unsigned   AW        = 16,
  parameter logic [AW-1:0] STAT_ADDR = 16'hFE01
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          por_i,
  input logic          lvd_i,
  input logic          wdt_ovf_i,
  input logic          bus_wr_i,
  input logic [AW-1:0] bus_addr_i,
  input logic          rst_pin_drv_o,
  input logic          int_rst_o,
  input logic          clk_en_o,
  input logic [7:0]    stat_q,
  input logic          any_evt
);

  assert_por_gates_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    por_i && !lvd_i |=> rst_pin_drv_o && !clk_en_o);

  assert_por_status_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    por_i |=> stat_q == 8'h80);

  assert_cop_bit_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_ovf_i && !por_i |=> stat_q[5]);

  assert_lvd_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lvd_i |=> rst_pin_drv_o && !clk_en_o && stat_q[1]);

  assert_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !por_i |=> (stat_q & $past(stat_q)) == $past(stat_q));

  assert_irst_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_pin_drv_o |=> int_rst_o);

  assert_irst_release_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rst_pin_drv_o |=> !int_rst_o);

  assert_gate_in_reset_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clk_en_o |-> rst_pin_drv_o);

  assert_readonly_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_wr_i && (bus_addr_i == STAT_ADDR) && !any_evt |=> $stable(stat_q));

endmodule

bind rstseq_top rstseq_chk #(
  .AW        (AW),
  .STAT_ADDR (STAT_ADDR)
) chk_i (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .por_i         (por_i),
  .lvd_i         (lvd_i),
  .wdt_ovf_i     (wdt_ovf_i),
  .bus_wr_i      (bus_wr_i),
  .bus_addr_i    (bus_addr_i),
  .rst_pin_drv_o (rst_pin_drv_o),
  .int_rst_o     (int_rst_o),
  .clk_en_o      (clk_en_o),
  .stat_q        (stat_q),
  .any_evt       (any_evt)
);

// File: tb/rstseq_top_tb_top.sv
module rstseq_top_tb_top;

  localparam int unsigned STAB = 40;
  localparam int unsigned TAIL = 6;
  localparam logic [15:0] SADDR = 16'hFE01;
  localparam logic [15:0] WADDR = 16'hFFFF;

  // kinds: 0 data read of unmapped, 1 cop, 2 illop, 3 stop en=1, 4 stop en=0,
  //        5 unmapped fetch, 6 por
  typedef struct packed {
    logic [3:0]  kind;
    logic [7:0]  stat;
    logic [15:0] low;
    logic [15:0] gated;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{4'd0, 8'h80, 16'd0,         16'd0},
    '{4'd1, 8'hA0, 16'(TAIL),     16'd0},
    '{4'd2, 8'hB0, 16'(TAIL),     16'd0},
    '{4'd3, 8'hB0, 16'd0,         16'd0},
    '{4'd4, 8'hB0, 16'(TAIL),     16'd0},
    '{4'd5, 8'hB8, 16'(TAIL),     16'd0},
    '{4'd6, 8'h80, 16'(STAB+TAIL),16'(STAB)},
    '{4'd1, 8'hA0, 16'(TAIL),     16'd0}
  };

  logic clk = 1'b0;
  logic rst_n;
  logic por, lvd, wdt, ilop, stp, stp_en, unm, fet, rd, wr;
  logic [15:0] addr;
  logic [7:0]  rdata;
  logic wclr, pin, irst, cen;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  rstseq_top #(
    .STAB_CYC (STAB),
    .TAIL_CYC (TAIL),
    .AW       (16),
    .STAT_ADDR(SADDR),
    .WDT_ADDR (WADDR)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .por_i(por), .lvd_i(lvd), .wdt_ovf_i(wdt),
    .illop_i(ilop), .stop_i(stp), .stop_en_i(stp_en), .unmapped_i(unm),
    .fetch_i(fet), .bus_addr_i(addr), .bus_rd_i(rd), .bus_wr_i(wr),
    .stat_rdata_o(rdata), .wdt_clr_o(wclr), .rst_pin_drv_o(pin),
    .int_rst_o(irst), .clk_en_o(cen)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic read_stat(output logic [7:0] v);
    addr = SADDR; rd = 1'b1;
    #1 v = rdata;
    rd = 1'b0; addr = 16'h0000;
  endtask

  task automatic pulse(input logic [3:0] kind);
    case (kind)
      4'd0: begin unm = 1; fet = 0; end
      4'd1: wdt = 1;
      4'd2: ilop = 1;
      4'd3: begin stp = 1; stp_en = 1; end
      4'd4: begin stp = 1; stp_en = 0; end
      4'd5: begin unm = 1; fet = 1; end
      4'd6: por = 1;
      default: ;
    endcase
    @(negedge clk);
    por = 0; wdt = 0; ilop = 0; stp = 0; stp_en = 1; unm = 0; fet = 0;
  endtask

  task automatic measure(input string tag, input int exp_low, input int exp_gated);
    int low = 0;
    int gated = 0;
    while (pin && low < 100000) begin
      if (!cen) gated++;
      low++;
      @(negedge clk);
    end
    chk({tag, " pin low cycles"}, low, exp_low);
    chk({tag, " gated cycles"}, gated, exp_gated);
    if (exp_low > 0) begin
      chk("R8 int_rst held one edge past pin release", int'(irst), 1);
      @(negedge clk);
    end
    chk("R8 int_rst released", int'(irst), 0);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] s;
    rst_n = 0; por = 0; lvd = 0; wdt = 0; ilop = 0; stp = 0; stp_en = 1;
    unm = 0; fet = 0; rd = 0; wr = 0; addr = 16'h0000;
    repeat (3) @(negedge clk);
    // reset state: R1, R2
    chk("R1 reset pin driven", int'(pin), 1);
    chk("R1 reset clocks gated", int'(cen), 0);
    chk("R8 reset int_rst", int'(irst), 1);
    read_stat(s);
    chk("R2 reset status", int'(s), 8'h80);
    rst_n = 1;
    @(negedge clk);
    measure("R1 reset sequence", STAB + TAIL - 1, STAB - 1);

    // vector walk: R2 R3 R4 R5 R7
    foreach (VECS[i]) begin
      pulse(VECS[i].kind);
      measure($sformatf("R3/R4/R5 vec%0d", i), int'(VECS[i].low), int'(VECS[i].gated));
      read_stat(s);
      chk($sformatf("R2/R7 vec%0d status", i), int'(s), int'(VECS[i].stat));
    end

    // low voltage: R6
    lvd = 1;
    @(negedge clk);
    repeat (4) @(negedge clk);
    chk("R6 lvd pin", int'(pin), 1);
    chk("R6 lvd gated", int'(cen), 0);
    lvd = 0;
    measure("R6 lvd release", STAB + 1, STAB + 1);
    read_stat(s);
    chk("R6 LVI bit kept with COP", int'(s), 8'hA2);

    // restart: R9
    pulse(4'd6);
    repeat (10) @(negedge clk);
    pulse(4'd1);
    measure("R9 restart", STAB + TAIL, STAB);
    read_stat(s);
    chk("R9 status after restart", int'(s), 8'hA0);

    // same-cycle POR and COP: R2
    por = 1; wdt = 1;
    @(negedge clk);
    por = 0; wdt = 0;
    measure("R2 coincident", STAB + TAIL, STAB);
    read_stat(s);
    chk("R2 coincident POR wins", int'(s), 8'h80);

    // bus: R10 R11
    addr = SADDR; rd = 0; #1;
    chk("R10 no read strobe", int'(rdata), 0);
    addr = 16'h1234; rd = 1; #1;
    chk("R10 wrong address", int'(rdata), 0);
    rd = 0;
    addr = SADDR; wr = 1; #1;
    chk("R11 no clear on status write", int'(wclr), 0);
    @(negedge clk);
    wr = 0;
    read_stat(s);
    chk("R10 write ignored", int'(s), 8'h80);
    addr = WADDR; wr = 1; #1;
    chk("R11 clear strobe", int'(wclr), 1);
    chk("R11 no reset from clear", int'(pin), 0);
    @(negedge clk);
    wr = 0; #1;
    chk("R11 strobe ends", int'(wclr), 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule